// File: doc/BRIEF.md
# Triggered Single-Shot Delay Timer

This block is a retriggerable-only-when-idle monostable. A one-cycle (or longer) high level on the trigger input, seen while the timer is at rest, starts a fixed-length wait of `DELAY_CYCLES` clock cycles (10000 by default). When that wait has run out, the block raises a completion strobe for a single clock cycle. It then returns to rest with its cycle counter frozen, so the completion can never repeat on its own.

A busy output is high for every cycle of the wait. It lets a neighbouring block tell that a trigger was taken and that the wait is still in progress. Trigger activity during the wait, and during the strobe cycle, is ignored. A trigger that is still held high after the strobe starts the next full wait on the first cycle back at rest. A synchronous reset cancels any wait in progress.

Top module: `oneshot_delay`

## Requirements
- R1: With `rst` high at a clock edge, both `finish_o` and `busy_o` are 0 after that edge, and no strobe follows until a new trigger arrives after `rst` falls.
- R2: A rising clock edge that samples `start_i`=1 while the timer is at rest begins a wait; `busy_o` is 1 after that edge.
- R3: `finish_o` rises on exactly the `DELAY_CYCLES`-th rising edge after the edge that sampled the trigger.
- R4: `finish_o` is high for exactly one clock cycle per accepted trigger.
- R5: After the strobe the timer stays at rest; with `start_i` held low, `finish_o` and `busy_o` remain 0 indefinitely.
- R6: `start_i` pulses during a wait are ignored: they neither restart nor extend the wait.
- R7: `start_i` is ignored during the strobe cycle; if it is held high continuously, consecutive strobes are `DELAY_CYCLES`+2 cycles apart.
- R8: `busy_o` is 1 for exactly `DELAY_CYCLES` cycles per wait, ending on the edge where `finish_o` rises, and is never 1 together with `finish_o`.
- R9: A synchronous reset during a wait aborts it; no strobe is produced for the aborted wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Trigger; sampled on each rising edge while at rest |
| finish_o | output | 1 | Registered one-cycle completion strobe |
| busy_o | output | 1 | Registered; high while a wait is in progress |

## Verification
A lone trigger pulse measures the trigger-to-strobe distance and the strobe width exactly. Extra pulses scattered inside a wait separate a timer that ignores them from one that restarts. A trigger held high for several periods shows whether the strobe cycle is skipped correctly, because the spacing must be exactly two cycles more than the delay. A reset in the middle of a wait, followed by sparse random triggers and occasional resets, is compared cycle by cycle against a bench model driven by the age of the current trigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    OS_REST  = 2'd0,
    OS_WAIT  = 2'd1,
    OS_FIRE  = 2'd2
  } os_state_e;

endpackage

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned LAST  = 9999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  output logic             term_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST_V);
  assign term_o  = en_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && !at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic term_i,
  output logic clr_o,
  output logic run_o,
  output logic finish_o,
  output logic busy_o
);

  os_state_e state_q, state_d;
  logic      finish_q, busy_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OS_REST: if (start_i) state_d = OS_WAIT;
      OS_WAIT: if (term_i)  state_d = OS_FIRE;
      OS_FIRE:              state_d = OS_REST;
      default:              state_d = OS_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= OS_REST;
      finish_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      finish_q <= (state_d == OS_FIRE);
      busy_q   <= (state_d == OS_WAIT);
    end
  end

  assign clr_o    = (state_q == OS_REST) && start_i;
  assign run_o    = (state_q == OS_WAIT);
  assign finish_o = finish_q;
  assign busy_o   = busy_q;

  // R4
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    finish_q |=> !finish_q);

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(finish_q && busy_q));

  // R3
  finish_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(finish_q) |-> $past(busy_q));

  // R7
  fire_to_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == OS_FIRE) |=> (state_q == OS_REST));

endmodule

// File: rtl/oneshot_delay.sv
module oneshot_delay #(
  parameter int unsigned DELAY_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic finish_o,
  output logic busy_o
);

  localparam int unsigned CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
  localparam int unsigned LAST  = DELAY_CYCLES - 1;

  initial begin
    if (DELAY_CYCLES < 2) $error("DELAY_CYCLES must be at least 2");
  end

  logic             clr, run, term;
  logic [CNT_W-1:0] cnt;

  oneshot_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .term_i   (term),
    .clr_o    (clr),
    .run_o    (run),
    .finish_o (finish_o),
    .busy_o   (busy_o)
  );

  oneshot_counter #(
    .CNT_W (CNT_W),
    .LAST  (LAST)
  ) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .en_i   (run),
    .term_o (term),
    .cnt_o  (cnt)
  );

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !finish_o && start_i) |=> busy_o);

  // R9
  abort_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !finish_o));

  // R1
  reset_count_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0));

endmodule

// File: tb/oneshot_delay_tb_top.sv
module oneshot_delay_tb_top;

  localparam int unsigned D = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic finish_o, busy_o;

  always #2 clk = ~clk;

  oneshot_delay #(.DELAY_CYCLES(D)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .finish_o(finish_o), .busy_o(busy_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  // reference: 0 rest, 1 waiting, 2 strobe; age = edges since trigger
  int m_mode = 0;
  int m_age = 0;
  int last_rise = -1;
  int last_trig = -1;
  bit prev_fin = 1'b0;
  int fin_len = 0;

  function automatic bit exp_busy(int mode);
    return mode == 1;
  endfunction

  function automatic bit exp_fin(int mode);
    return mode == 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(bit s, bit r);
    @(negedge clk);
    start_i = s;
    rst = r;
    @(posedge clk);
    cyc++;
    if (r) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: if (s) begin m_mode = 1; m_age = 0; last_trig = cyc; end
        1: begin
             m_age++;
             if (m_age == int'(D)) m_mode = 2;
           end
        default: m_mode = 0;
      endcase
    end
    #1;
    chk(cur_req, "finish_o", finish_o, exp_fin(m_mode));
    chk(cur_req, "busy_o", busy_o, exp_busy(m_mode));
    if (finish_o && !prev_fin) last_rise = cyc;
    if (finish_o) fin_len++;
    prev_fin = finish_o;
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", wd);
    summary();
  end

  initial begin
    int t0, r1, r2;
    void'($urandom(32'd7321));

    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    chk("R1", "finish_o after reset", finish_o, 0);
    chk("R1", "busy_o after reset", busy_o, 0);

    // R2/R3/R4/R8: lone trigger
    cur_req = "R3";
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    t0 = last_trig;
    chk("R2", "busy_o after trigger", busy_o, 1);
    fin_len = 0;
    for (int i = 0; i < int'(D) + 3; i++) step(1'b0, 1'b0);
    chk("R3", "trigger to strobe distance", last_rise - t0, D);
    chk("R4", "strobe width", fin_len, 1);

    // R5: stays at rest
    cur_req = "R5";
    fin_len = 0;
    for (int i = 0; i < 400; i++) step(1'b0, 1'b0);
    chk("R5", "strobes while idle", fin_len, 0);

    // R6: pulses during wait ignored
    cur_req = "R6";
    step(1'b1, 1'b0);
    t0 = last_trig;
    for (int i = 0; i < int'(D) + 3; i++) step(($urandom_range(0, 19) == 0), 1'b0);
    chk("R6", "distance with retrigger pulses", last_rise - t0, D);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);

    // R7: held trigger
    cur_req = "R7";
    step(1'b1, 1'b0);
    for (int i = 0; i < int'(D) + 4; i++) step(1'b1, 1'b0);
    r1 = last_rise;
    for (int i = 0; i < int'(D) + 2; i++) step(1'b1, 1'b0);
    r2 = last_rise;
    chk("R7", "held-trigger strobe spacing", r2 - r1, D + 2);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    // R9: reset mid-wait
    cur_req = "R9";
    step(1'b1, 1'b0);
    for (int i = 0; i < 5000; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    fin_len = 0;
    for (int i = 0; i < int'(D) + 50; i++) step(1'b0, 1'b0);
    chk("R9", "strobes after abort", fin_len, 0);

    // R2/R3 random mix
    cur_req = "R2";
    for (int i = 0; i < 60000; i++)
      step(($urandom_range(0, 2999) == 0), ($urandom_range(0, 19999) == 0));

    summary();
  end

endmodule